// File: doc/BRIEF.md
# Sequenced Color Palette Port

This block is a color lookup table with 260 entries. Each entry holds an 8-bit red, an 8-bit green and an 8-bit blue value. Entries 0 to 255 are pseudocolor entries, addressed by a pixel index. Entries 256 to 259 form a small overlay bank used for cursor colors.

Software reaches the table through a 32-bit, word-addressed register window of 16 bytes. One write loads a shared entry pointer. After that, successive data accesses walk through the three color components of the pointed entry. After the third component the pointer moves to the next entry by itself, so a run of writes or reads can load or dump the whole table without reloading the pointer.

Two side ports give the display pipeline combinational access to the table:
- an 8-bit pixel index returns that pseudocolor entry;
- a 2-bit select returns one overlay entry.

Top module: `palette_port`

## Requirements
- R1: After reset every component of every entry is 0x00, except entries 255, 256 and 258, which are white (0xFF in red, green and blue). The pointer and the component phase are zero, and `busRdata` is zero.
- R2: A write at byte offset 0 loads the pointer from `busWdata[31:24]` and returns the phase to red.
- R3: A write at byte offset 4 stores `busWdata[31:24]` into the current component of pseudocolor entry [pointer]. Only that byte changes. The lookup port shows the new value from the next clock edge on.
- R4: A write at byte offset 12 stores `busWdata[31:24]` into the current component of overlay entry 256 + pointer[1:0]. No pseudocolor entry changes.
- R5: Data accesses step through the components in the order red, green, blue. After blue the pointer advances by one modulo 256 and the phase returns to red. This holds for reads, for writes and for any mix of the two.
- R6: A read, accepted at any offset, puts the current component of pseudocolor entry [pointer] into `busRdata[31:24]` with zeros in bits 23:0 on the next clock edge, and advances the phase. `busRdata` holds its value while no read is accepted.
- R7: A write at byte offset 8, or at any offset that is not 0, 4 or 12, changes no entry, no pointer and no phase.
- R8: `pixRgb` shows entry [`pixIndex`] and `ovlRgb` shows entry 256 + `ovlSel`, both combinationally, packed as red in bits 23:16, green in bits 15:8 and blue in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busValid | input | 1 | Register access accepted this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busOffset | input | 4 | Byte offset inside the register window |
| busWdata | input | 32 | Write data; bits 31:24 carry the byte |
| busRdata | output | 32 | Read data, valid the cycle after a read |
| pixIndex | input | 8 | Pseudocolor lookup index |
| pixRgb | output | 24 | Color of entry `pixIndex` |
| ovlSel | input | 2 | Overlay lookup select |
| ovlRgb | output | 24 | Color of overlay entry `ovlSel` |

## Verification
The pointer and the phase are not visible at the ports, so any fault in them shows up as a misplaced byte. A wrong phase puts a byte in the wrong component of `pixRgb`. A wrong pointer puts it in the wrong entry, or makes a read return a neighbour's component. In both cases the error appears on the lookup ports or on `busRdata` one clock after the faulty access.

The bench drives the lookup ports to the entry being written. It compares both lookup outputs and the read data against a behavioural model on every clock, so a slip is caught at the first affected access rather than at a final table dump. Full-table sweeps after reset and at the end catch writes that land in unexpected entries.

// File: rtl/palette_pkg.sv
`timescale 1ns/1ps
package palette_pkg;

  // Component phase of the shared access sequence.
  typedef enum logic [1:0] {
    PH_RED   = 2'd0,
    PH_GREEN = 2'd1,
    PH_BLUE  = 2'd2
  } phase_t;

  // Strobes from the sequencing control to the table datapath.
  typedef struct packed {
    logic   wrEn;       // store one component byte
    logic   toOverlay;  // target the overlay bank
    logic   rdEn;       // capture one component for read data
    phase_t comp;       // component selected by the phase
  } palStrobe_t;

endpackage

// File: rtl/palette_ctrl.sv
`timescale 1ns/1ps
module palette_ctrl
  import palette_pkg::*;
#(
  parameter int IDX_W      = 8,
  parameter int OFF_W      = 4,
  parameter int OFF_INDEX  = 0,
  parameter int OFF_BASE   = 4,
  parameter int OFF_OVL    = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busValid,
  input  logic             busWrite,
  input  logic [OFF_W-1:0] busOffset,
  input  logic [IDX_W-1:0] idxByte,
  output logic [IDX_W-1:0] idx,
  output palStrobe_t       strobe
);

  phase_t phase;
  logic   isIdx, isBase, isOvl, isRead, dataAcc, isIgnored;

  always_comb begin
    isIdx     = busValid && busWrite && (busOffset == OFF_W'(OFF_INDEX));
    isBase    = busValid && busWrite && (busOffset == OFF_W'(OFF_BASE));
    isOvl     = busValid && busWrite && (busOffset == OFF_W'(OFF_OVL));
    isRead    = busValid && !busWrite;
    dataAcc   = isBase || isOvl || isRead;
    isIgnored = busValid && busWrite && !isIdx && !isBase && !isOvl;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx   <= '0;
      phase <= PH_RED;
    end else if (isIdx) begin
      idx   <= idxByte;
      phase <= PH_RED;
    end else if (dataAcc) begin
      case (phase)
        PH_RED:   phase <= PH_GREEN;
        PH_GREEN: phase <= PH_BLUE;
        default: begin
          phase <= PH_RED;
          idx   <= idx + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    strobe.wrEn      = isBase || isOvl;
    strobe.toOverlay = isOvl;
    strobe.rdEn      = isRead;
    strobe.comp      = phase;
  end

  // R5: the phase never leaves the three-step sequence
  assert_phase_legal_R5: assert property (@(posedge clk) disable iff (!rstN)
    phase inside {PH_RED, PH_GREEN, PH_BLUE});

  // R2: a pointer write loads the byte and restarts at red
  assert_index_load_R2: assert property (@(posedge clk) disable iff (!rstN)
    isIdx |=> (idx == $past(idxByte)) && (phase == PH_RED));

  // R5: the access after blue advances the pointer modulo its width
  assert_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    (dataAcc && !isIdx && phase == PH_BLUE) |=>
      (idx == IDX_W'($past(idx) + 1'b1)) && (phase == PH_RED));

  // R7: writes to undecoded offsets leave the sequencing state alone
  assert_ignore_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    isIgnored |=> $stable(idx) && $stable(phase));

endmodule

// File: rtl/palette_store.sv
`timescale 1ns/1ps
module palette_store
  import palette_pkg::*;
#(
  parameter int NUM_BASE = 256,
  parameter int NUM_OVL  = 4,
  parameter int COMP_W   = 8,
  parameter int IDX_W    = 8,
  parameter int OVL_W    = 2,
  parameter int DATA_W   = 32,
  localparam int ENTRIES = NUM_BASE + NUM_OVL,
  localparam int ADDR_W  = $clog2(ENTRIES),
  localparam int RGB_W   = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  palStrobe_t        strobe,
  input  logic [IDX_W-1:0]  idx,
  input  logic [COMP_W-1:0] wrByte,
  input  logic [IDX_W-1:0]  pixIndex,
  input  logic [OVL_W-1:0]  ovlSel,
  output logic [DATA_W-1:0] busRdata,
  output logic [RGB_W-1:0]  pixRgb,
  output logic [RGB_W-1:0]  ovlRgb
);

  logic [ENTRIES-1:0][RGB_W-1:0] colorTable;
  logic [ADDR_W-1:0] wrAddr;
  logic [RGB_W-1:0]  rdEntry;
  logic [COMP_W-1:0] rdByte;

  always_comb begin
    if (strobe.toOverlay)
      wrAddr = ADDR_W'(NUM_BASE) + ADDR_W'(idx[OVL_W-1:0]);
    else
      wrAddr = ADDR_W'(idx);
  end

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    localparam bit IS_WHITE = (e == NUM_BASE - 1) || (e == NUM_BASE) ||
                              (e == NUM_BASE + 2);
    localparam logic [RGB_W-1:0] INIT = IS_WHITE ? {RGB_W{1'b1}} : '0;
    logic [RGB_W-1:0] ent;
    logic hit;
    assign hit = strobe.wrEn && (wrAddr == ADDR_W'(e));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ent <= INIT;
      end else if (hit) begin
        case (strobe.comp)
          PH_RED:   ent[RGB_W-1 -: COMP_W]    <= wrByte;
          PH_GREEN: ent[2*COMP_W-1 -: COMP_W] <= wrByte;
          default:  ent[COMP_W-1:0]           <= wrByte;
        endcase
      end
    end
    assign colorTable[e] = ent;
  end

  always_comb begin
    rdEntry = colorTable[ADDR_W'(idx)];
    case (strobe.comp)
      PH_RED:   rdByte = rdEntry[RGB_W-1 -: COMP_W];
      PH_GREEN: rdByte = rdEntry[2*COMP_W-1 -: COMP_W];
      default:  rdByte = rdEntry[COMP_W-1:0];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busRdata <= '0;
    else if (strobe.rdEn)
      busRdata <= {rdByte, {(DATA_W-COMP_W){1'b0}}};
  end

  assign pixRgb = colorTable[ADDR_W'(pixIndex)];
  assign ovlRgb = colorTable[ADDR_W'(NUM_BASE) + ADDR_W'(ovlSel)];

  // R6: read data carries the byte only in the top lane
  assert_rdata_low_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdEn |=> (busRdata[DATA_W-COMP_W-1:0] == '0));

  // R6: read data holds while no read is accepted
  assert_rdata_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.rdEn |=> $stable(busRdata));

  // R4: an overlay write never alters the pseudocolor entry at the pointer
  assert_ovl_isolation_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrEn && strobe.toOverlay) |=>
      (colorTable[ADDR_W'($past(idx))] == $past(colorTable[ADDR_W'(idx)])));

endmodule

// File: rtl/palette_port.sv
`timescale 1ns/1ps
module palette_port
  import palette_pkg::*;
#(
  parameter int NUM_BASE  = 256,
  parameter int NUM_OVL   = 4,
  parameter int COMP_W    = 8,
  parameter int OFF_W     = 4,
  parameter int DATA_W    = 32,
  localparam int IDX_W    = $clog2(NUM_BASE),
  localparam int OVL_W    = $clog2(NUM_OVL),
  localparam int RGB_W    = 3 * COMP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [OFF_W-1:0]  busOffset,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [IDX_W-1:0]  pixIndex,
  output logic [RGB_W-1:0]  pixRgb,
  input  logic [OVL_W-1:0]  ovlSel,
  output logic [RGB_W-1:0]  ovlRgb
);

  logic [IDX_W-1:0] idx;
  palStrobe_t       strobe;
  logic             unusedLow;

  assign unusedLow = ^busWdata[DATA_W-COMP_W-1:0];

  palette_ctrl #(
    .IDX_W    (IDX_W),
    .OFF_W    (OFF_W),
    .OFF_INDEX(0),
    .OFF_BASE (4),
    .OFF_OVL  (12)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busValid (busValid),
    .busWrite (busWrite),
    .busOffset(busOffset),
    .idxByte  (busWdata[DATA_W-1 -: IDX_W]),
    .idx      (idx),
    .strobe   (strobe)
  );

  palette_store #(
    .NUM_BASE(NUM_BASE),
    .NUM_OVL (NUM_OVL),
    .COMP_W  (COMP_W),
    .IDX_W   (IDX_W),
    .OVL_W   (OVL_W),
    .DATA_W  (DATA_W)
  ) u_store (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .idx     (idx),
    .wrByte  (busWdata[DATA_W-1 -: COMP_W]),
    .pixIndex(pixIndex),
    .ovlSel  (ovlSel),
    .busRdata(busRdata),
    .pixRgb  (pixRgb),
    .ovlRgb  (ovlRgb)
  );

endmodule

// File: tb/palette_port_test.sv
`timescale 1ns/1ps
module palette_port_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0;
  logic        busWrite = 1'b0;
  logic [3:0]  busOffset = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  pixIndex = '0;
  logic [23:0] pixRgb;
  logic [1:0]  ovlSel = '0;
  logic [23:0] ovlRgb;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural model
  logic [7:0]  mr [0:259];
  logic [7:0]  mg [0:259];
  logic [7:0]  mb [0:259];
  int          mIdx;
  int          mPh;
  logic [31:0] expRd;

  always #4 clk = ~clk;  // 125 MHz

  palette_port uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busOffset(busOffset), .busWdata(busWdata), .busRdata(busRdata),
    .pixIndex(pixIndex), .pixRgb(pixRgb), .ovlSel(ovlSel), .ovlRgb(ovlRgb)
  );

  function automatic logic [23:0] mEntry(int e);
    return {mr[e], mg[e], mb[e]};
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic modelReset();
    for (int e = 0; e < 260; e++) begin
      mr[e] = 8'h00; mg[e] = 8'h00; mb[e] = 8'h00;
    end
    foreach (mr[e]) if (e == 255 || e == 256 || e == 258) begin
      mr[e] = 8'hFF; mg[e] = 8'hFF; mb[e] = 8'hFF;
    end
    mIdx = 0; mPh = 0; expRd = '0;
  endtask

  task automatic modelAdvance();
    if (mPh == 2) begin
      mPh = 0;
      mIdx = (mIdx + 1) % 256;
    end else begin
      mPh++;
    end
  endtask

  task automatic modelAccess(logic w, logic [3:0] off, logic [31:0] d);
    int e;
    if (w) begin
      if (off == 4'd0) begin
        mIdx = d[31:24]; mPh = 0;
      end else if (off == 4'd4 || off == 4'd12) begin
        e = (off == 4'd12) ? 256 + (mIdx % 4) : mIdx;
        case (mPh)
          0: mr[e] = d[31:24];
          1: mg[e] = d[31:24];
          default: mb[e] = d[31:24];
        endcase
        modelAdvance();
      end
    end else begin
      case (mPh)
        0: expRd = {mr[mIdx], 24'h0};
        1: expRd = {mg[mIdx], 24'h0};
        default: expRd = {mb[mIdx], 24'h0};
      endcase
      modelAdvance();
    end
  endtask

  // one clock with an optional access, compared after the edge
  task automatic step(logic v, logic w, logic [3:0] off, logic [31:0] d, string tag);
    @(negedge clk);
    busValid = v; busWrite = w; busOffset = off; busWdata = d;
    @(posedge clk);
    if (v) modelAccess(w, off, d);
    #2;
    busValid = 1'b0;
    chk(tag, "busRdata", busRdata, expRd);
    chk(tag, "pixRgb", {8'h0, pixRgb}, {8'h0, mEntry(pixIndex)});
    chk(tag, "ovlRgb", {8'h0, ovlRgb}, {8'h0, mEntry(256 + ovlSel)});
  endtask

  task automatic wr(logic [3:0] off, logic [7:0] b, string tag);
    step(1'b1, 1'b1, off, {b, 24'h5A_A5_3C}, tag);
  endtask

  task automatic rd(logic [3:0] off, string tag);
    step(1'b1, 1'b0, off, 32'h0, tag);
  endtask

  task automatic sweep(string tag);
    for (int i = 0; i < 256; i++) begin
      pixIndex = 8'(i);
      #1;
      chk(tag, "sweep pixRgb", {8'h0, pixRgb}, {8'h0, mEntry(i)});
    end
    for (int j = 0; j < 4; j++) begin
      ovlSel = 2'(j);
      #1;
      chk(tag, "sweep ovlRgb", {8'h0, ovlRgb}, {8'h0, mEntry(256 + j)});
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset contents, read data zero
    chk("R1", "busRdata reset", busRdata, 32'h0);
    sweep("R1");

    // R2, R3: load pointer and fill entry 10 byte by byte
    pixIndex = 8'd10; ovlSel = 2'd0;
    wr(4'd0, 8'd10, "R2");
    wr(4'd4, 8'h11, "R3");
    wr(4'd4, 8'h22, "R3");
    wr(4'd4, 8'h33, "R3");
    // R5: pointer now 11
    pixIndex = 8'd11;
    wr(4'd4, 8'h44, "R5");

    // R2: reload mid-sequence restarts at red; R3 touches only red
    pixIndex = 8'd20;
    wr(4'd0, 8'd20, "R2");
    wr(4'd4, 8'hAB, "R3");
    wr(4'd0, 8'd20, "R2");
    wr(4'd4, 8'hCD, "R3");
    wr(4'd4, 8'hEF, "R3");

    // R5: wrap from 255 to 0
    pixIndex = 8'd255;
    wr(4'd0, 8'd255, "R5");
    wr(4'd4, 8'h01, "R5");
    wr(4'd4, 8'h02, "R5");
    wr(4'd4, 8'h03, "R5");
    pixIndex = 8'd0;
    wr(4'd4, 8'h77, "R5");

    // R4: overlay writes map to 256 + pointer[1:0]
    pixIndex = 8'd5; ovlSel = 2'd1;
    wr(4'd0, 8'd5, "R4");
    wr(4'd12, 8'h10, "R4");
    wr(4'd12, 8'h20, "R4");
    wr(4'd12, 8'h30, "R4");
    ovlSel = 2'd2; pixIndex = 8'd6;
    wr(4'd12, 8'h40, "R4");

    // R6: reads of entry 10, low lanes zero, data held when idle
    pixIndex = 8'd10;
    wr(4'd0, 8'd10, "R6");
    rd(4'd4, "R6");
    rd(4'd0, "R6");
    step(1'b0, 1'b0, 4'd0, 32'h0, "R6");
    rd(4'd8, "R6");
    rd(4'd4, "R6");
    step(1'b0, 1'b0, 4'd0, 32'h0, "R6");

    // R5: mixed reads and writes share one phase counter
    pixIndex = 8'd30;
    wr(4'd0, 8'd30, "R5");
    wr(4'd4, 8'h9A, "R5");
    rd(4'd4, "R5");
    wr(4'd4, 8'h9C, "R5");
    pixIndex = 8'd31;
    rd(4'd4, "R5");

    // R7: undecoded offsets are ignored, sequence continues untouched
    pixIndex = 8'd40; ovlSel = 2'd0;
    wr(4'd0, 8'd40, "R7");
    wr(4'd4, 8'h61, "R7");
    wr(4'd8, 8'hEE, "R7");
    wr(4'd2, 8'hEE, "R7");
    wr(4'd15, 8'hEE, "R7");
    wr(4'd13, 8'hEE, "R7");
    wr(4'd4, 8'h62, "R7");
    wr(4'd4, 8'h63, "R7");

    // R8: lookup ports over the whole table
    sweep("R8");

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule